// File: doc/BRIEF.md
# Endpoint Calibration Pin Handshake Controller

This block runs the calibration handshake of a capacitance measurement front end that keeps two endpoint values, a low endpoint and a high endpoint, used to scale a PWM output. Each endpoint has its own open-drain style calibration line. The host pulls a line high to request a calibration of that endpoint. Once the line has stayed high long enough, the block drives the line high itself and averages a fixed number of acquisition results. It then stops driving the line. The host sees the line fall back when it lets go, and that is the signal that the block is done. The new endpoint is committed only after the line actually reads low.

The acquisition engine feeds the block with a one-cycle strobe and the raw count of each finished burst. The block keeps both endpoint registers and gives them to the PWM scaler. It raises a hold output that freezes the PWM value for the whole calibration. The nonvolatile store appears only as a one-cycle write strobe with an endpoint select. After reset the block waits through a start-up interval, and it treats both lines as idle until that interval ends.

Top module: `endpoint_cal_ctrl`

## Requirements
- R1: After reset both line drives, `pwm_hold` and `nv_wr` are 0, `ep_lo` equals `LO_RESET` (default 0) and `ep_hi` equals `HI_RESET` (default all ones).
- R2: A request is accepted only after the line has read high on `QUAL_CYCLES` consecutive synchronised cycles. A shorter pulse has no effect.
- R3: Once a request is accepted, the block drives that line high (`*_pin_oe` = 1) until exactly `NSAMP` (15) `burst_done` strobes have been taken. It releases the drive on the strobe that completes the set.
- R4: The new endpoint is the floor of the 20-bit sum of the `NSAMP` sampled counts divided by `NSAMP`.
- R5: The endpoint register and a single one-cycle `nv_wr` pulse change only once the line reads low after the drive is released. `nv_sel` is 0 for the low endpoint and 1 for the high endpoint. While the host keeps the line high, nothing is committed.
- R6: Calibrating one endpoint leaves the other endpoint register unchanged.
- R7: During the first `POWERUP_CYCLES` cycles after reset, a high line is ignored and leads to no drive and no commit.
- R8: `pwm_hold` is 1 from the cycle the drive starts through the cycle before the commit pulse, and 0 once the commit is done.
- R9: If both lines are accepted together, the low endpoint is served first. The high endpoint is served right after the commit if its line is still high.
- R10: At most one line drive is active at any time.
- R11: `burst_done` strobes that arrive while no calibration is running do not affect the next endpoint value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_pin_in | input | 1 | Sensed level of the low-endpoint calibration line |
| lo_pin_oe | output | 1 | Drive-high enable for the low-endpoint line |
| hi_pin_in | input | 1 | Sensed level of the high-endpoint calibration line |
| hi_pin_oe | output | 1 | Drive-high enable for the high-endpoint line |
| burst_done | input | 1 | One-cycle strobe: an acquisition burst finished |
| burst_count | input | CNT_W | Raw count of the finished burst |
| ep_lo | output | CNT_W | Low endpoint register |
| ep_hi | output | CNT_W | High endpoint register |
| pwm_hold | output | 1 | Freeze request to the PWM path |
| nv_wr | output | 1 | One-cycle nonvolatile write strobe |
| nv_sel | output | 1 | Endpoint being written (0 low, 1 high) |
| pu_done | output | 1 | Start-up interval has elapsed |

## Verification
The averaging path gets ramps of counts with different slopes, a constant run whose sum leaves a remainder, a run at full-scale count, and a run that is nonzero only in its last sample. Together these separate a true floor division by fifteen from a shift, from dropping the last sample, and from a sum that is too narrow. Line patterns cover five cases: a host that lets go early, so the device's own drive must hold the line, and a host that keeps holding, so the commit must wait. A pulse shorter than the qualifying time, a line held only during start-up, and both lines raised at once each tell apart the qualification, start-up masking and priority rules. Strobes that arrive while idle show whether the accumulator is cleared at the start of a calibration.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Controller phases
  typedef enum logic [1:0] {
    CS_BOOT    = 2'd0,
    CS_IDLE    = 2'd1,
    CS_SAMPLE  = 2'd2,
    CS_RELEASE = 2'd3
  } cal_state_t;

  // Which endpoint a calibration is working on; the value is nv_sel
  typedef enum logic {
    END_LO = 1'b0,
    END_HI = 1'b1
  } cal_end_t;

  localparam int unsigned NUM_ENDS = 2;

endpackage

// File: rtl/cal_powerup_timer.sv
module cal_powerup_timer #(
  parameter int unsigned POWERUP_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned PW = $clog2(POWERUP_CYCLES + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != PW'(POWERUP_CYCLES)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == PW'(POWERUP_CYCLES));

endmodule

// File: rtl/cal_pin_qualifier.sv
// Synchronises one calibration line and measures how long it has been high.
module cal_pin_qualifier #(
  parameter int unsigned QUAL_CYCLES = 125_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_raw,
  output logic level,
  output logic req
);
  localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);

  logic          s1_q, s2_q;
  logic [QW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_raw;
      s2_q <= s1_q;
    end
  end

  // Counts consecutive high cycles, saturating at the qualifying length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
    end else if (!enable || !s2_q) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q != QW'(QUAL_CYCLES)) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign level = s2_q;
  assign req   = (hi_cnt_q == QW'(QUAL_CYCLES));

endmodule

// File: rtl/cal_sample_accum.sv
// Sums a fixed number of burst counts and forms their floor mean.
module cal_sample_accum #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SUM_W = 20,
  parameter int unsigned NSAMP = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             burst_done,
  input  logic [CNT_W-1:0] burst_count,
  output logic             last,
  output logic [CNT_W-1:0] mean
);
  localparam int unsigned NW = $clog2(NSAMP + 1);

  function automatic logic [CNT_W-1:0] mean_of(input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] q;
    q = s / SUM_W'(NSAMP);
    return q[CNT_W-1:0];
  endfunction

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_next;
  logic [NW-1:0]    n_q;
  logic             take;

  assign take     = active && burst_done;
  assign sum_next = sum_q + SUM_W'(burst_count);
  assign last     = take && (n_q == NW'(NSAMP - 1));
  assign mean     = mean_of(sum_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      n_q   <= '0;
    end else if (!active) begin
      sum_q <= '0;
      n_q   <= '0;
    end else if (take) begin
      sum_q <= sum_next;
      n_q   <= n_q + 1'b1;
    end
  end

endmodule

// File: rtl/endpoint_cal_ctrl.sv
module endpoint_cal_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned SUM_W          = 20,
  parameter int unsigned NSAMP          = 15,
  parameter int unsigned QUAL_CYCLES    = 125_000,
  parameter int unsigned POWERUP_CYCLES = 10_000_000,
  parameter logic [CNT_W-1:0] LO_RESET  = '0,
  parameter logic [CNT_W-1:0] HI_RESET  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_pin_in,
  output logic             lo_pin_oe,
  input  logic             hi_pin_in,
  output logic             hi_pin_oe,
  input  logic             burst_done,
  input  logic [CNT_W-1:0] burst_count,
  output logic [CNT_W-1:0] ep_lo,
  output logic [CNT_W-1:0] ep_hi,
  output logic             pwm_hold,
  output logic             nv_wr,
  output logic             nv_sel,
  output logic             pu_done
);

  // Named internal events
  logic [NUM_ENDS-1:0] pin_raw;
  logic [NUM_ENDS-1:0] pin_level;
  logic [NUM_ENDS-1:0] pin_req;
  logic                sampling;
  logic                acc_last;
  logic [CNT_W-1:0]    acc_mean;
  logic                start_lo, start_hi, commit;

  cal_state_t       state_q;
  cal_end_t         sel_q;
  logic [CNT_W-1:0] pending_q;
  logic [CNT_W-1:0] ep_lo_q, ep_hi_q;
  logic             nv_wr_q;
  cal_end_t         nv_sel_q;

  assign pin_raw = {hi_pin_in, lo_pin_in};

  cal_powerup_timer #(.POWERUP_CYCLES(POWERUP_CYCLES)) u_pu (
    .clk  (clk),
    .rst_n(rst_n),
    .done (pu_done)
  );

  for (genvar g = 0; g < NUM_ENDS; g++) begin : g_pin
    cal_pin_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (pu_done),
      .pin_raw(pin_raw[g]),
      .level  (pin_level[g]),
      .req    (pin_req[g])
    );
  end

  assign sampling = (state_q == CS_SAMPLE);

  cal_sample_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W), .NSAMP(NSAMP)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (sampling),
    .burst_done (burst_done),
    .burst_count(burst_count),
    .last       (acc_last),
    .mean       (acc_mean)
  );

  // Low endpoint wins a tie
  assign start_lo = (state_q == CS_IDLE) && pin_req[END_LO];
  assign start_hi = (state_q == CS_IDLE) && !pin_req[END_LO] && pin_req[END_HI];
  assign commit   = (state_q == CS_RELEASE) && !pin_level[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_BOOT;
      sel_q     <= END_LO;
      pending_q <= '0;
    end else begin
      unique case (state_q)
        CS_BOOT: if (pu_done) state_q <= CS_IDLE;
        CS_IDLE: begin
          if (start_lo) begin
            sel_q   <= END_LO;
            state_q <= CS_SAMPLE;
          end else if (start_hi) begin
            sel_q   <= END_HI;
            state_q <= CS_SAMPLE;
          end
        end
        CS_SAMPLE: begin
          if (acc_last) begin
            pending_q <= acc_mean;
            state_q   <= CS_RELEASE;
          end
        end
        CS_RELEASE: if (commit) state_q <= CS_IDLE;
        default: state_q <= CS_BOOT;
      endcase
    end
  end

  // Endpoint registers and the nonvolatile write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_lo_q  <= LO_RESET;
      ep_hi_q  <= HI_RESET;
      nv_wr_q  <= 1'b0;
      nv_sel_q <= END_LO;
    end else begin
      nv_wr_q <= commit;
      if (commit) begin
        nv_sel_q <= sel_q;
        if (sel_q == END_LO) ep_lo_q <= pending_q;
        else                 ep_hi_q <= pending_q;
      end
    end
  end

  assign lo_pin_oe = sampling && (sel_q == END_LO);
  assign hi_pin_oe = sampling && (sel_q == END_HI);
  assign pwm_hold  = (state_q == CS_SAMPLE) || (state_q == CS_RELEASE);
  assign ep_lo     = ep_lo_q;
  assign ep_hi     = ep_hi_q;
  assign nv_wr     = nv_wr_q;
  assign nv_sel    = nv_sel_q;

endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NSAMP = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lo_pin_in,
  input logic             hi_pin_in,
  input logic             lo_pin_oe,
  input logic             hi_pin_oe,
  input logic             burst_done,
  input logic [CNT_W-1:0] ep_lo,
  input logic [CNT_W-1:0] ep_hi,
  input logic             pwm_hold,
  input logic             nv_wr,
  input logic             nv_sel,
  input logic             pu_done
);
  localparam int unsigned NW = $clog2(NSAMP + 2);

  logic          any_oe;
  logic [NW-1:0] strobes_q;

  assign any_oe = lo_pin_oe || hi_pin_oe;

  // Strobes seen while a line is being driven
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           strobes_q <= '0;
    else if (!any_oe)     strobes_q <= '0;
    else if (burst_done)  strobes_q <= strobes_q + 1'b1;
  end

  assert_single_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lo_pin_oe, hi_pin_oe}) <= 1);

  assert_hold_covers_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_oe |-> pwm_hold);

  assert_commit_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> ($past(pwm_hold) && !pwm_hold));

  assert_boot_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_done |-> (!any_oe && !nv_wr));

  assert_sample_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_oe) |-> (strobes_q == NW'(NSAMP)));

  assert_commit_lo_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr && !nv_sel) |-> !$past(lo_pin_in));

  assert_commit_hi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr && nv_sel) |-> !$past(hi_pin_in));

  assert_lo_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_wr && !nv_sel) |-> $stable(ep_lo));

  assert_hi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_wr && nv_sel) |-> $stable(ep_hi));

endmodule

bind endpoint_cal_ctrl cal_checker #(.CNT_W(CNT_W), .NSAMP(NSAMP)) u_cal_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .lo_pin_in (lo_pin_in),
  .hi_pin_in (hi_pin_in),
  .lo_pin_oe (lo_pin_oe),
  .hi_pin_oe (hi_pin_oe),
  .burst_done(burst_done),
  .ep_lo     (ep_lo),
  .ep_hi     (ep_hi),
  .pwm_hold  (pwm_hold),
  .nv_wr     (nv_wr),
  .nv_sel    (nv_sel),
  .pu_done   (pu_done)
);

// File: tb/sim_endpoint_cal_ctrl.sv
module sim_endpoint_cal_ctrl;
  localparam int CNT_W = 16;
  localparam int QUAL  = 40;
  localparam int PU    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_lo = 1'b0, host_hi = 1'b0;
  logic lo_pin_in, hi_pin_in, lo_pin_oe, hi_pin_oe;
  logic burst_done = 1'b0;
  logic [CNT_W-1:0] burst_count = '0;
  logic [CNT_W-1:0] ep_lo, ep_hi;
  logic pwm_hold, nv_wr, nv_sel, pu_done;

  int checks = 0, errors = 0;
  int nv_n = 0;
  logic nv_last_sel = 1'b0;

  always #10 clk = ~clk;

  // Line with pull-down: high if host or device drives it
  assign lo_pin_in = host_lo | lo_pin_oe;
  assign hi_pin_in = host_hi | hi_pin_oe;

  endpoint_cal_ctrl #(.QUAL_CYCLES(QUAL), .POWERUP_CYCLES(PU)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lo_pin_in(lo_pin_in), .lo_pin_oe(lo_pin_oe),
    .hi_pin_in(hi_pin_in), .hi_pin_oe(hi_pin_oe),
    .burst_done(burst_done), .burst_count(burst_count),
    .ep_lo(ep_lo), .ep_hi(ep_hi), .pwm_hold(pwm_hold),
    .nv_wr(nv_wr), .nv_sel(nv_sel), .pu_done(pu_done)
  );

  always @(posedge clk) begin
    if (rst_n && nv_wr) begin
      nv_n = nv_n + 1;
      nv_last_sel = nv_sel;
    end
  end

  // Vectors: endpoint, base, step, extra on last sample, host keeps holding, expected
  localparam int NV = 5;
  localparam int V_END  [NV] = '{0, 1, 0, 1, 0};
  localparam int V_BASE [NV] = '{1000, 40000, 500, 65535, 0};
  localparam int V_STEP [NV] = '{10, 100, 0, 0, 0};
  localparam int V_XTRA [NV] = '{0, 0, 14, 0, 29};
  localparam int V_KEEP [NV] = '{1, 0, 1, 0, 1};
  localparam int V_EXP  [NV] = '{1070, 40700, 500, 65535, 1};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_host(input int e, input logic v);
    if (e == 0) host_lo = v; else host_hi = v;
  endtask

  function automatic logic oe_of(input int e);
    return (e == 0) ? lo_pin_oe : hi_pin_oe;
  endfunction

  function automatic logic [CNT_W-1:0] ep_of(input int e);
    return (e == 0) ? ep_lo : ep_hi;
  endfunction

  task automatic strobe(input int val);
    burst_count = CNT_W'(val);
    burst_done = 1'b1;
    tick(1);
    burst_done = 1'b0;
    tick(2);
  endtask

  task automatic run_cal(input int e, input int base, input int step,
                         input int xtra, input int keep, input int exp);
    int n0;
    logic [CNT_W-1:0] other0, this0;
    n0 = nv_n;
    other0 = ep_of(1 - e);
    this0 = ep_of(e);
    set_host(e, 1'b1);
    tick(QUAL - 2);
    chk("R2 drive not yet", 32'(oe_of(e)), 0);
    tick(8);
    chk("R3 drive on", 32'(oe_of(e)), 1);
    chk("R8 hold on", 32'(pwm_hold), 1);
    if (keep == 0) set_host(e, 1'b0);
    for (int i = 0; i < 14; i++) strobe(base + i * step);
    chk("R3 drive holds line", 32'((e == 0) ? lo_pin_in : hi_pin_in), 1);
    strobe(base + 14 * step + xtra);
    if (keep != 0) begin
      tick(2);
      chk("R5 drive released", 32'(oe_of(e)), 0);
      chk("R5 no commit while held", 32'(nv_n), 32'(n0));
      chk("R5 endpoint unchanged while held", 32'(ep_of(e)), 32'(this0));
      chk("R8 hold until commit", 32'(pwm_hold), 1);
      set_host(e, 1'b0);
    end
    tick(8);
    chk("R5 one commit", 32'(nv_n), 32'(n0 + 1));
    chk("R5 commit select", 32'(nv_last_sel), 32'(e));
    chk("R4 endpoint mean", 32'(ep_of(e)), 32'(exp));
    chk("R6 other endpoint", 32'(ep_of(1 - e)), 32'(other0));
    chk("R8 hold released", 32'(pwm_hold), 0);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    host_lo = 1'b1;  // held through start-up (R7)
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 lo drive", 32'(lo_pin_oe), 0);
    chk("R1 hi drive", 32'(hi_pin_oe), 0);
    chk("R1 hold", 32'(pwm_hold), 0);
    chk("R1 nv_wr", 32'(nv_wr), 0);
    chk("R1 ep_lo", 32'(ep_lo), 0);
    chk("R1 ep_hi", 32'(ep_hi), 32'hFFFF);

    tick(PU - 20);
    host_lo = 1'b0;
    tick(40);
    chk("R7 no drive after start-up hold", 32'(lo_pin_oe), 0);
    chk("R7 no commit", 32'(nv_n), 0);

    // Short pulse
    host_hi = 1'b1;
    tick(QUAL / 2);
    host_hi = 1'b0;
    tick(QUAL + 10);
    chk("R2 short pulse no drive", 32'(hi_pin_oe), 0);
    chk("R2 short pulse no commit", 32'(nv_n), 0);

    // Idle strobes
    for (int i = 0; i < 5; i++) strobe(9999);
    chk("R11 idle strobes no commit", 32'(nv_n), 0);
    chk("R11 idle strobes ep_lo", 32'(ep_lo), 0);

    for (int v = 0; v < NV; v++)
      run_cal(V_END[v], V_BASE[v], V_STEP[v], V_XTRA[v], V_KEEP[v], V_EXP[v]);

    // Both requests together
    host_lo = 1'b1;
    host_hi = 1'b1;
    tick(QUAL + 8);
    chk("R9 low served first", 32'(lo_pin_oe), 1);
    chk("R9 high waits", 32'(hi_pin_oe), 0);
    chk("R10 single drive", 32'(lo_pin_oe & hi_pin_oe), 0);
    host_lo = 1'b0;
    for (int i = 0; i < 15; i++) strobe(300);
    tick(8);
    chk("R9 low committed", 32'(ep_lo), 300);
    chk("R9 high served next", 32'(hi_pin_oe), 1);
    host_hi = 1'b0;
    for (int i = 0; i < 15; i++) strobe(2000);
    tick(8);
    chk("R9 high committed", 32'(ep_hi), 2000);
    chk("R6 low kept", 32'(ep_lo), 300);
    chk("R5 commit count", 32'(nv_n), 32'(NV + 2));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule